// File: doc/BRIEF.md
# Banked RAM Word Access Unit

This block carries out the byte and word loads and stores that a coprocessor issues against a byte-addressed RAM. Each request names an operation, an 8-bit bank value, a 16-bit offset and 16-bit store data. The block builds a 24-bit physical address with the bank in the top byte and the offset below it. It then runs one or two byte accesses on a synchronous single-port byte RAM that it contains. For loads, it returns the 16-bit result together with a one-cycle completion strobe.

The offset is used in one of three ways. It can be taken as given, which covers the register-indirect and long-immediate forms. It can be built from an 8-bit short immediate doubled. Or it can be replaced by the last address the block touched, which is how a store-back works. A word never straddles two byte pairs. It always uses the even/odd pair that holds the offset. When the offset is odd, the two byte lanes trade places, for both reads and writes. Every operation keeps the block busy for a fixed number of cycles, set per operation, and the block reports that count.

Top module: `bank_ram_port`

## Requirements
- R1: For register and long forms the accessed physical address is {reqBank, reqOffset}, and after acceptance lastAddr shows that 24-bit value.
- R2: For short forms (codes 6 and 7) the offset is reqOffset[7:0] shifted left by one, with bits 15:9 zero. reqOffset[15:8] has no effect.
- R3: A word access uses only the byte pair {offset[15:1],0} and {offset[15:1],1}. For an even offset, data bits 7:0 live at the even byte and bits 15:8 at the odd byte.
- R4: For an odd offset the lanes are exchanged: data bits 7:0 live at the odd byte and bits 15:8 at the even byte. This applies to loads and stores alike.
- R5: A byte load (code 1) returns the RAM byte in bits 7:0 with bits 15:8 zero. A byte store (code 3) writes reqData[7:0] to the exact address and leaves the other byte of the pair unchanged.
- R6: Every accepted access records its address in lastAddr. A store-back (code 8) writes a word at lastAddr with the same odd-address lane exchange, ignores reqBank and reqOffset, and leaves lastAddr unchanged.
- R7: After acceptance, busy stays high for cost+1 cycles and opCost shows the cost. The costs are: code 0 register word load 7, code 1 register byte load 6, code 2 register word store 1, code 3 register byte store 1, code 4 long load 4, code 5 long store 4, code 6 short load 3, code 7 short store 3, code 8 store-back 1.
- R8: done is high for exactly one cycle, in the cycle right after the last busy cycle. busy and done are never high together.
- R9: A request is accepted only when busy is low. A request made while busy, or with a code of 9 to 15, causes no access, no busy and no change to lastAddr.
- R10: After reset busy, done, loadData, lastAddr and opCost are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqOp | input | 4 | Operation code (see R7) |
| reqBank | input | 8 | RAM bank value, address bits 23:16 |
| reqOffset | input | 16 | Register or immediate offset |
| reqData | input | 16 | Store data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| loadData | output | 16 | Result of the most recent load |
| lastAddr | output | 24 | Last accessed physical address |
| opCost | output | 4 | Busy cycle count of the current or last operation |

## Verification
The bench builds the block with a 64-byte RAM (MEM_AW = 6) and the default costs. The small RAM lets it write a word at every one of the 64 offsets, with both alignments and overlapping pairs, and then read back every byte and every word against an arithmetic model. Offsets and banks carry nonzero upper bits that alias onto the small RAM, so the address formation rules (R1, R2) are seen through lastAddr while the lane rules (R3 to R6) are seen through the data. The bench measures cycle counts for each operation code and probes requests made while busy and with illegal codes.

// File: rtl/bank_ram_pkg.sv
package bank_ram_pkg;

  typedef enum logic [3:0] {
    OP_LDW_REG  = 4'd0,
    OP_LDB_REG  = 4'd1,
    OP_STW_REG  = 4'd2,
    OP_STB_REG  = 4'd3,
    OP_LD_LONG  = 4'd4,
    OP_ST_LONG  = 4'd5,
    OP_LD_SHORT = 4'd6,
    OP_ST_SHORT = 4'd7,
    OP_ST_BACK  = 4'd8
  } memOp_e;

  typedef enum logic [1:0] {
    AM_REG   = 2'd0,
    AM_LONG  = 2'd1,
    AM_SHORT = 2'd2,
    AM_LAST  = 2'd3
  } addrMode_e;

  typedef struct packed {
    logic      legal;
    logic      isWord;
    logic      isStore;
    addrMode_e mode;
  } opInfo_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      accept;
    addrMode_e mode;
    logic      isWord;
    logic      isStore;
    logic      memEn;
    logic      secondByte;
    logic      capFirst;
    logic      capSecond;
  } ctlStrobe_t;

  function automatic opInfo_t decodeOp(input logic [3:0] op);
    opInfo_t info;
    info = '{legal: 1'b1, isWord: 1'b1, isStore: 1'b0, mode: AM_REG};
    case (op)
      OP_LDW_REG:  info = '{1'b1, 1'b1, 1'b0, AM_REG};
      OP_LDB_REG:  info = '{1'b1, 1'b0, 1'b0, AM_REG};
      OP_STW_REG:  info = '{1'b1, 1'b1, 1'b1, AM_REG};
      OP_STB_REG:  info = '{1'b1, 1'b0, 1'b1, AM_REG};
      OP_LD_LONG:  info = '{1'b1, 1'b1, 1'b0, AM_LONG};
      OP_ST_LONG:  info = '{1'b1, 1'b1, 1'b1, AM_LONG};
      OP_LD_SHORT: info = '{1'b1, 1'b1, 1'b0, AM_SHORT};
      OP_ST_SHORT: info = '{1'b1, 1'b1, 1'b1, AM_SHORT};
      OP_ST_BACK:  info = '{1'b1, 1'b1, 1'b1, AM_LAST};
      default:     info = '{1'b0, 1'b0, 1'b0, AM_REG};
    endcase
    return info;
  endfunction

endpackage

// File: rtl/bank_ram_store.sv
module bank_ram_store #(
  parameter int MEM_AW = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [MEM_AW-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/bank_ram_ctrl.sv
module bank_ram_ctrl
  import bank_ram_pkg::*;
#(
  parameter int COST_W       = 4,
  parameter int COST_LDW_REG = 7,
  parameter int COST_LDB_REG = 6,
  parameter int COST_STW_REG = 1,
  parameter int COST_STB_REG = 1,
  parameter int COST_LONG    = 4,
  parameter int COST_SHORT   = 3,
  parameter int COST_BACK    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [3:0]        reqOp,
  output ctlStrobe_t        stb,
  output logic              busy,
  output logic              done,
  output logic [COST_W-1:0] opCost
);
  localparam int COST_MAX = (1 << COST_W) - 1;

  // word loads need three busy cycles to capture two bytes, byte loads two
  initial begin
    assert (COST_LDW_REG >= 2 && COST_LONG >= 2 && COST_SHORT >= 2)
      else $error("word load cost below 2");
    assert (COST_LDB_REG >= 1 && COST_STW_REG >= 1 && COST_BACK >= 1)
      else $error("cost below 1");
    assert (COST_LDW_REG <= COST_MAX && COST_LDB_REG <= COST_MAX &&
            COST_LONG <= COST_MAX && COST_SHORT <= COST_MAX &&
            COST_STW_REG <= COST_MAX && COST_STB_REG <= COST_MAX &&
            COST_BACK <= COST_MAX)
      else $error("cost exceeds counter width");
  end

  opInfo_t           reqInfo;
  opInfo_t           curInfo;
  logic              accept;
  logic [COST_W-1:0] costSel;
  logic [COST_W-1:0] cnt;
  logic [1:0]        phase;

  assign reqInfo = decodeOp(reqOp);
  assign accept  = reqValid && !busy && reqInfo.legal;

  always_comb begin
    case (reqOp)
      OP_LDW_REG:               costSel = COST_W'(COST_LDW_REG);
      OP_LDB_REG:               costSel = COST_W'(COST_LDB_REG);
      OP_STW_REG:               costSel = COST_W'(COST_STW_REG);
      OP_STB_REG:               costSel = COST_W'(COST_STB_REG);
      OP_LD_LONG, OP_ST_LONG:   costSel = COST_W'(COST_LONG);
      OP_LD_SHORT, OP_ST_SHORT: costSel = COST_W'(COST_SHORT);
      OP_ST_BACK:               costSel = COST_W'(COST_BACK);
      default:                  costSel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      phase   <= '0;
      opCost  <= '0;
      curInfo <= '{1'b0, 1'b0, 1'b0, AM_REG};
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        cnt     <= costSel;
        phase   <= '0;
        curInfo <= reqInfo;
        opCost  <= costSel;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        if (phase != 2'd3) phase <= phase + 2'd1;
      end
    end
  end

  always_comb begin
    stb.accept     = accept;
    stb.mode       = reqInfo.mode;
    stb.isWord     = curInfo.isWord;
    stb.isStore    = curInfo.isStore;
    stb.memEn      = busy && ((phase == 2'd0) || (phase == 2'd1 && curInfo.isWord));
    stb.secondByte = (phase == 2'd1);
    stb.capFirst   = busy && !curInfo.isStore && (phase == 2'd1);
    stb.capSecond  = busy && !curInfo.isStore && curInfo.isWord && (phase == 2'd2);
  end

  // R8: completion strobe lasts one cycle
  p_done_once_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8: never busy and done together
  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));
  // R8: done only directly after a busy cycle
  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));
  // R7: a busy window only ends through completion
  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));
  // R9: a running operation is not replaced by new requests
  p_op_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid) |=> $stable(opCost));
endmodule

// File: rtl/bank_ram_dpath.sv
module bank_ram_dpath
  import bank_ram_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 16,
  parameter int MEM_AW = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                stb,
  input  logic [BANK_W-1:0]         reqBank,
  input  logic [OFF_W-1:0]          reqOffset,
  input  logic [DATA_W-1:0]         reqData,
  input  logic [DATA_W/2-1:0]       rdData,
  output logic [MEM_AW-1:0]         memAddr,
  output logic                      memEn,
  output logic                      memWe,
  output logic [DATA_W/2-1:0]       wrByte,
  output logic [DATA_W-1:0]         loadData,
  output logic [BANK_W+OFF_W-1:0]   lastAddr
);
  localparam int ADDR_W = BANK_W + OFF_W;
  localparam int BYTE_W = DATA_W / 2;
  localparam int PAD_W  = OFF_W - BYTE_W - 1;

  logic [ADDR_W-1:0] effAddr;
  logic [OFF_W-1:0]  shortOff;
  logic [MEM_AW-1:0] aReg;
  logic [DATA_W-1:0] dReg;
  logic              oddWord;

  assign shortOff = {{PAD_W{1'b0}}, reqOffset[BYTE_W-1:0], 1'b0};

  always_comb begin
    case (stb.mode)
      AM_SHORT: effAddr = {reqBank, shortOff};
      AM_LAST:  effAddr = lastAddr;
      default:  effAddr = {reqBank, reqOffset};
    endcase
  end

  assign oddWord = stb.isWord && aReg[0];

  // word accesses stay in the aligned pair: even byte first, odd byte second
  assign memAddr = stb.isWord ? {aReg[MEM_AW-1:1], stb.secondByte} : aReg;
  assign memEn   = stb.memEn;
  assign memWe   = stb.memEn && stb.isStore;
  assign wrByte  = (stb.isWord && (stb.secondByte ^ aReg[0])) ?
                   dReg[DATA_W-1:BYTE_W] : dReg[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg     <= '0;
      dReg     <= '0;
      lastAddr <= '0;
      loadData <= '0;
    end else begin
      if (stb.accept) begin
        aReg     <= effAddr[MEM_AW-1:0];
        dReg     <= reqData;
        lastAddr <= effAddr;
      end
      if (stb.capFirst) begin
        if (!stb.isWord) loadData <= {{BYTE_W{1'b0}}, rdData};
        else if (oddWord) loadData[DATA_W-1:BYTE_W] <= rdData;
        else loadData[BYTE_W-1:0] <= rdData;
      end
      if (stb.capSecond) begin
        if (oddWord) loadData[BYTE_W-1:0] <= rdData;
        else loadData[DATA_W-1:BYTE_W] <= rdData;
      end
    end
  end

  // R6: last address only moves on an accepted request
  p_last_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.accept |=> $stable(lastAddr));
  // R6: store-back keeps the recorded address
  p_back_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.accept && stb.mode == AM_LAST) |=> $stable(lastAddr));
  // R2: short offsets are even and small
  p_short_even_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.accept && stb.mode == AM_SHORT) |=>
      (lastAddr[0] == 1'b0 && lastAddr[OFF_W-1:BYTE_W+1] == '0));
  // R3: second byte of a word is the odd partner of the first
  p_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.memEn && stb.secondByte) |->
      (memAddr[0] && memAddr[MEM_AW-1:1] == $past(memAddr[MEM_AW-1:1])));
endmodule

// File: rtl/bank_ram_port.sv
module bank_ram_port
  import bank_ram_pkg::*;
#(
  parameter int BANK_W       = 8,
  parameter int OFF_W        = 16,
  parameter int DATA_W       = 16,
  parameter int MEM_AW       = 10,
  parameter int COST_W       = 4,
  parameter int COST_LDW_REG = 7,
  parameter int COST_LDB_REG = 6,
  parameter int COST_STW_REG = 1,
  parameter int COST_STB_REG = 1,
  parameter int COST_LONG    = 4,
  parameter int COST_SHORT   = 3,
  parameter int COST_BACK    = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [3:0]              reqOp,
  input  logic [BANK_W-1:0]       reqBank,
  input  logic [OFF_W-1:0]        reqOffset,
  input  logic [DATA_W-1:0]       reqData,
  output logic                    busy,
  output logic                    done,
  output logic [DATA_W-1:0]       loadData,
  output logic [BANK_W+OFF_W-1:0] lastAddr,
  output logic [COST_W-1:0]       opCost
);
  localparam int BYTE_W = DATA_W / 2;

  ctlStrobe_t        stb;
  logic [MEM_AW-1:0] memAddr;
  logic              memEn;
  logic              memWe;
  logic [BYTE_W-1:0] wrByte;
  logic [BYTE_W-1:0] rdByte;

  bank_ram_ctrl #(
    .COST_W(COST_W), .COST_LDW_REG(COST_LDW_REG), .COST_LDB_REG(COST_LDB_REG),
    .COST_STW_REG(COST_STW_REG), .COST_STB_REG(COST_STB_REG),
    .COST_LONG(COST_LONG), .COST_SHORT(COST_SHORT), .COST_BACK(COST_BACK)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .stb(stb), .busy(busy), .done(done), .opCost(opCost)
  );

  bank_ram_dpath #(
    .BANK_W(BANK_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqBank(reqBank),
    .reqOffset(reqOffset), .reqData(reqData), .rdData(rdByte),
    .memAddr(memAddr), .memEn(memEn), .memWe(memWe), .wrByte(wrByte),
    .loadData(loadData), .lastAddr(lastAddr)
  );

  bank_ram_store #(.MEM_AW(MEM_AW), .BYTE_W(BYTE_W)) i_store (
    .clk(clk), .en(memEn), .we(memWe), .addr(memAddr),
    .wdata(wrByte), .rdata(rdByte)
  );
endmodule

// File: tb/test_bank_ram_port.sv
module test_bank_ram_port;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW = 6;
  localparam int DEPTH = 1 << MEM_AW;

  localparam logic [3:0] C_LDW = 4'd0, C_LDB = 4'd1, C_STW = 4'd2, C_STB = 4'd3,
                         C_LDL = 4'd4, C_STL = 4'd5, C_LDS = 4'd6, C_STS = 4'd7,
                         C_SBK = 4'd8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [3:0] reqOp = '0;
  logic [7:0] reqBank = '0;
  logic [15:0] reqOffset = '0;
  logic [15:0] reqData = '0;
  logic busy, done;
  logic [15:0] loadData;
  logic [23:0] lastAddr;
  logic [3:0] opCost;

  int nChecks = 0;
  int nErrors = 0;
  logic [7:0] mdl [DEPTH];
  logic [15:0] lastLoad;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_ram_port #(.MEM_AW(MEM_AW)) i_bank_ram_port (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqBank(reqBank), .reqOffset(reqOffset), .reqData(reqData),
    .busy(busy), .done(done), .loadData(loadData), .lastAddr(lastAddr),
    .opCost(opCost)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int costOf(input logic [3:0] op);
    case (op)
      C_LDW: return 7;
      C_LDB: return 6;
      C_STW, C_STB, C_SBK: return 1;
      C_LDL, C_STL: return 4;
      default: return 3;
    endcase
  endfunction

  // word as seen at an offset: low lane at the offset byte, high lane at its partner
  function automatic logic [15:0] wordAt(input int a);
    return {mdl[a ^ 1], mdl[a]};
  endfunction

  task automatic putWord(input int a, input logic [15:0] d);
    mdl[a]     = d[7:0];
    mdl[a ^ 1] = d[15:8];
  endtask

  // issue one request at a negedge, wait for completion, check timing (R7, R8)
  task automatic runOp(input logic [3:0] op, input logic [7:0] bank,
                       input logic [15:0] off, input logic [15:0] data);
    int n;
    int cost;
    cost = costOf(op);
    reqValid = 1'b1; reqOp = op; reqBank = bank; reqOffset = off; reqData = data;
    @(negedge clk);
    reqValid = 1'b0;
    check("R7", "busy after accept", 32'(busy), 32'd1);
    n = 1;
    while (done !== 1'b1 && n < 64) begin
      @(negedge clk);
      if (done !== 1'b1) n++;
    end
    check("R7", "busy cycles", 32'(n), 32'(cost + 1));
    check("R7", "opCost", 32'(opCost), 32'(cost));
    check("R8", "busy low with done", 32'(busy), 32'd0);
    lastLoad = loadData;
    @(negedge clk);
    check("R8", "done single cycle", 32'(done), 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin : stimulus
    logic [7:0] bank;
    logic [15:0] off;
    logic [15:0] d;
    logic [23:0] keep;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10", "busy", 32'(busy), 0);
    check("R10", "done", 32'(done), 0);
    check("R10", "loadData", 32'(loadData), 0);
    check("R10", "lastAddr", 32'(lastAddr), 0);
    check("R10", "opCost", 32'(opCost), 0);

    // word store at every offset, overlapping pairs (R1, R3, R4)
    for (int a = 0; a < DEPTH; a++) begin
      bank = 8'(a * 37 + 1);
      off = 16'((a * 1024) | a);
      d = 16'((a * 16'h0101) ^ 16'h5A3C);
      runOp(C_STW, bank, off, d);
      putWord(a, d);
      check("R1", "lastAddr after register store", 32'(lastAddr), 32'({bank, off}));
    end
    // every byte (R3, R4, R5)
    for (int b = 0; b < DEPTH; b++) begin
      runOp(C_LDB, 8'h00, 16'(b), 16'h0);
      check("R4", "byte after word stores", 32'(lastLoad), 32'({8'h00, mdl[b]}));
    end
    // every word (R3, R4)
    for (int a = 0; a < DEPTH; a++) begin
      runOp(C_LDW, 8'(a), 16'((a * 512) | a), 16'h0);
      check("R3", "register word load", 32'(lastLoad), 32'(wordAt(a)));
    end

    // long form (R1, R4)
    for (int a = 0; a < 8; a++) begin
      d = 16'(16'hC000 + a * 16'h1111);
      off = 16'(16'hA5C0 | (a + 3));
      runOp(C_STL, 8'hE1, off, d);
      putWord(a + 3, d);
      check("R1", "lastAddr long store", 32'(lastAddr), 32'({8'hE1, off}));
      runOp(C_LDL, 8'h7F, 16'h3340 | 16'(a + 3), 16'h0);
      check("R4", "long load", 32'(lastLoad), 32'(wordAt(a + 3)));
      check("R1", "lastAddr long load", 32'(lastAddr), 32'({8'h7F, 16'h3340 | 16'(a + 3)}));
    end

    // short form (R2)
    for (int k = 0; k < DEPTH / 2; k++) begin
      d = 16'(16'h0F00 ^ (k * 16'h0907));
      runOp(C_STS, 8'h3C, {8'hFF, 8'(k)}, d);
      putWord(2 * k, d);
      check("R2", "lastAddr short store", 32'(lastAddr), 32'({8'h3C, 16'(2 * k)}));
    end
    for (int k = 0; k < DEPTH / 2; k++) begin
      runOp(C_LDS, 8'h11, {8'hA5, 8'(8'hE0 | k)}, 16'h0);
      check("R2", "short load data", 32'(lastLoad), 32'(wordAt(2 * k)));
      check("R2", "lastAddr short load", 32'(lastAddr), 32'({8'h11, 16'(16'h01C0 + 2 * k)}));
    end

    // byte store and zero extension (R5)
    runOp(C_STB, 8'h02, 16'h0009, 16'hC37E);
    mdl[9] = 8'h7E;
    runOp(C_LDB, 8'h02, 16'h0008, 16'h0);
    check("R5", "partner byte untouched", 32'(lastLoad), 32'({8'h00, mdl[8]}));
    runOp(C_LDB, 8'h02, 16'h0009, 16'h0);
    check("R5", "stored low byte only", 32'(lastLoad), 32'h007E);
    runOp(C_STB, 8'h02, 16'h000A, 16'h99FF);
    mdl[10] = 8'hFF;
    runOp(C_LDB, 8'h02, 16'h000A, 16'h0);
    check("R5", "zero-extended byte", 32'(lastLoad), 32'h00FF);

    // store-back at odd and even recorded addresses (R6)
    runOp(C_LDW, 8'h44, 16'h120D, 16'h0);
    keep = lastAddr;
    runOp(C_SBK, 8'h99, 16'h0020, 16'hBEEF);
    putWord(13, 16'hBEEF);
    check("R6", "lastAddr kept by store-back", 32'(lastAddr), 32'(keep));
    runOp(C_LDB, 8'h00, 16'h000C, 16'h0);
    check("R6", "store-back odd high lane", 32'(lastLoad), 32'h00BE);
    runOp(C_LDB, 8'h00, 16'h000D, 16'h0);
    check("R6", "store-back odd low lane", 32'(lastLoad), 32'h00EF);
    runOp(C_STB, 8'h05, 16'h0016, 16'h0000);
    mdl[22] = 8'h00;
    runOp(C_SBK, 8'h00, 16'h0001, 16'h1234);
    putWord(22, 16'h1234);
    runOp(C_LDW, 8'h00, 16'h0016, 16'h0);
    check("R6", "store-back even word", 32'(lastLoad), 32'h1234);
    runOp(C_LDW, 8'h00, 16'h0017, 16'h0);
    check("R6", "store-back even pair swapped view", 32'(lastLoad), 32'h3412);

    // illegal codes (R9)
    keep = lastAddr;
    for (int c = 9; c < 16; c++) begin
      reqValid = 1'b1; reqOp = 4'(c); reqBank = 8'hAA; reqOffset = 16'h0004; reqData = 16'hFFFF;
      @(negedge clk);
      reqValid = 1'b0;
      check("R9", "illegal code not busy", 32'(busy), 0);
      @(negedge clk);
      check("R9", "illegal code no done", 32'(done), 0);
      check("R9", "illegal code lastAddr", 32'(lastAddr), 32'(keep));
    end
    runOp(C_LDW, 8'h00, 16'h0004, 16'h0);
    check("R9", "illegal code no write", 32'(lastLoad), 32'(wordAt(4)));

    // request while busy (R9)
    reqValid = 1'b1; reqOp = C_STW; reqBank = 8'h02; reqOffset = 16'd20; reqData = 16'h1357;
    @(negedge clk);
    reqOp = C_STB; reqOffset = 16'd30; reqData = 16'h00AA;
    @(negedge clk);
    reqValid = 1'b0;
    putWord(20, 16'h1357);
    for (int w = 0; w < 8 && done !== 1'b1; w++) @(negedge clk);
    check("R8", "done after busy request", 32'(done), 1);
    check("R9", "lastAddr ignores busy request", 32'(lastAddr), 32'({8'h02, 16'd20}));
    @(negedge clk);
    runOp(C_LDB, 8'h00, 16'd30, 16'h0);
    check("R9", "busy request no write", 32'(lastLoad), 32'({8'h00, mdl[30]}));
    runOp(C_LDW, 8'h00, 16'd20, 16'h0);
    check("R9", "first request completed", 32'(lastLoad), 32'h1357);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule